// File: doc/BRIEF.md
# Pipelined Converter Digital Correction

This block sits behind the analog stages of a fourteen-stage pipelined converter. Every stage resolves one and a half bits, so it reports one of three decisions (minus one, zero, plus one) for each sample. Stage k handles a sample k cycles after the first stage does, so the decisions for one sample reach the block spread over fourteen clock cycles. The block holds each stage's decision in its own delay line until all fourteen decisions of the same sample are present together. It then adds them with binary weights that overlap from stage to stage, so that a wrong decision made by an early stage is made up by the later ones. The sum is clamped to the output range.

Each clock cycle the block receives one set of stage decisions and returns one registered 14-bit word with a valid flag. It also returns a flag for a clamped result and a flag for a word built from an illegal stage code. The analog side is not part of the block.

Top module: `adcc_correct`

## Requirements
- R1: Each stage code uses two bits: 2'b00 means -1, 2'b01 means 0 and 2'b10 means +1. Stage k sits at bits [2k+1:2k] of `stage_codes_i`. The word equals 8192 plus the sum of each stage value times 2^(13-k), so stage 0 carries the largest weight.
- R2: Stage k presents its code for a sample k cycles after stage 0 presents its code. The corrected word for that sample appears on `word_o` just after the rising edge that captures the stage 13 code. A new word follows on every cycle after that.
- R3: When the weighted sum is below 0 the output is 0. When it is above 16383 the output is 16383.
- R4: `over_range_o` is high for exactly those words that R3 clamped, and in the same cycle as the word.
- R5: The code 2'b11 is illegal. It adds nothing to the sum, and `code_err_o` is high together with the word it affected.
- R6: `word_vld_o` is low during reset. It stays low until the 14th rising edge after reset is released, then stays high on every cycle until the next reset.
- R7: During reset, and while `word_vld_o` is low, `word_o`, `over_range_o` and `code_err_o` are all zero.
- R8: Each comparator threshold of a 1.5-bit stage may be displaced by up to one eighth of the reference. For an input inside the full scale, the word then still lies within ±1 LSB of an ideal 14-bit quantiser of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_codes_i | input | 28 | One 2-bit decision per stage, stage k at [2k+1:2k] |
| word_o | output | 14 | Corrected, clamped output word |
| word_vld_o | output | 1 | The word on `word_o` is valid |
| over_range_o | output | 1 | The word was clamped to a rail |
| code_err_o | output | 1 | The word included an illegal stage code |

## Verification
The bench builds the block with its default of fourteen stages. This exercises every delay depth from zero to thirteen, the full 16384-code output span and both clamp rails. A behavioural stage model adds random comparator offsets, so each stage's redundancy is used. The same model takes inputs up to twice the full scale, which reaches the over-range flag from both sides. Hand-built code sets pin down single weights. Illegal codes are injected at the first, middle and last stage. A reset in the middle of the stream checks that the pipeline fills again.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    typedef logic [1:0] stage_code_t;

    localparam stage_code_t CODE_NEG  = 2'b00;
    localparam stage_code_t CODE_ZERO = 2'b01;
    localparam stage_code_t CODE_POS  = 2'b10;
    localparam stage_code_t CODE_BAD  = 2'b11;

    // +1, 0 or -1 contribution of one stage decision; illegal counts as zero
    function automatic logic code_is_pos(stage_code_t c);
        return c == CODE_POS;
    endfunction

    function automatic logic code_is_neg(stage_code_t c);
        return c == CODE_NEG;
    endfunction

    function automatic logic code_is_bad(stage_code_t c);
        return c == CODE_BAD;
    endfunction

endpackage

// File: rtl/adcc_stage_delay.sv
module adcc_stage_delay
    import adcc_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  stage_code_t din,
    output stage_code_t dout
);

    stage_code_t [DEPTH-1:0] line_d, line_q;

    always_comb begin
        line_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= {DEPTH{CODE_ZERO}};
        end else begin
            line_q <= line_d;
        end
    end

    assign dout = line_q[DEPTH-1];

endmodule

// File: rtl/adcc_overlap_sum.sv
module adcc_overlap_sum
    import adcc_pkg::*;
#(
    parameter int NSTAGE = 14,
    parameter int OUT_W  = 14
) (
    input  stage_code_t [NSTAGE-1:0] codes_i,
    output logic [OUT_W-1:0]         word_o,
    output logic                     ovr_o,
    output logic                     err_o
);

    localparam int SUM_W = NSTAGE + 3;
    localparam logic signed [SUM_W-1:0] MID_S = SUM_W'(1) << (OUT_W - 1);
    localparam logic signed [SUM_W-1:0] MAX_S = (SUM_W'(1) << OUT_W) - SUM_W'(1);

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc   = MID_S;
        err_o = 1'b0;
        for (int k = 0; k < NSTAGE; k++) begin
            if (code_is_pos(codes_i[k])) begin
                acc = acc + (SUM_W'(1) << (NSTAGE - 1 - k));
            end else if (code_is_neg(codes_i[k])) begin
                acc = acc - (SUM_W'(1) << (NSTAGE - 1 - k));
            end
            if (code_is_bad(codes_i[k])) begin
                err_o = 1'b1;
            end
        end
        if (acc < 0) begin
            word_o = '0;
            ovr_o  = 1'b1;
        end else if (acc > MAX_S) begin
            word_o = '1;
            ovr_o  = 1'b1;
        end else begin
            word_o = acc[OUT_W-1:0];
            ovr_o  = 1'b0;
        end
    end

endmodule

// File: rtl/adcc_fill_tracker.sv
module adcc_fill_tracker #(
    parameter int FILL = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);

    localparam int CW = $clog2(FILL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } fill_t;

    fill_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (st_q.cnt == CW'(FILL - 1)) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.done | (st_q.cnt == CW'(FILL - 1));

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);  // R6

endmodule

// File: rtl/adcc_correct.sv
module adcc_correct
    import adcc_pkg::*;
#(
    parameter int NSTAGE = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NSTAGE-1:0]   stage_codes_i,
    output logic [NSTAGE-1:0]     word_o,
    output logic                  word_vld_o,
    output logic                  over_range_o,
    output logic                  code_err_o
);

    localparam int OUT_W = NSTAGE;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             vld;
        logic             ovr;
        logic             err;
    } out_t;

    stage_code_t [NSTAGE-1:0] aligned;
    logic [OUT_W-1:0]         sum_word;
    logic                     sum_ovr;
    logic                     sum_err;
    logic                     fill_ready;
    out_t                     out_d, out_q;

    // stage k lags stage 0 by k cycles: delay it by the remainder
    for (genvar k = 0; k < NSTAGE; k++) begin : g_align
        if (k == NSTAGE - 1) begin : g_direct
            assign aligned[k] = stage_codes_i[2*k +: 2];
        end else begin : g_delay
            adcc_stage_delay #(.DEPTH(NSTAGE - 1 - k)) u_dly (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (stage_codes_i[2*k +: 2]),
                .dout (aligned[k])
            );
        end
    end

    adcc_overlap_sum #(.NSTAGE(NSTAGE), .OUT_W(OUT_W)) u_sum (
        .codes_i(aligned),
        .word_o (sum_word),
        .ovr_o  (sum_ovr),
        .err_o  (sum_err)
    );

    adcc_fill_tracker #(.FILL(NSTAGE)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready_o(fill_ready)
    );

    always_comb begin
        out_d = '0;
        if (fill_ready) begin
            out_d.word = sum_word;
            out_d.vld  = 1'b1;
            out_d.ovr  = sum_ovr;
            out_d.err  = sum_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o       = out_q.word;
    assign word_vld_o   = out_q.vld;
    assign over_range_o = out_q.ovr;
    assign code_err_o   = out_q.err;

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |=> !word_vld_o);  // R6

    AST_OVR_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        over_range_o |-> (word_o == '0 || word_o == '1));  // R4

    AST_QUIET_UNFILLED: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> (word_o == '0 && !over_range_o && !code_err_o));  // R7

endmodule

// File: tb/adcc_correct_bench.sv
module adcc_correct_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NST = 14;
    localparam int F   = 24;
    localparam int NS  = 400;
    localparam int MID = 8192;
    localparam int MAXW = 16383;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*NST-1:0] codes = '0;
    logic [NST-1:0]  word;
    logic            vld, ovr, err;

    int    code_mem [NS][NST];
    int    exp_word [NS];
    bit    exp_ovr  [NS];
    bit    exp_err  [NS];
    int    ideal    [NS];
    longint off_hi  [NST];
    longint off_lo  [NST];
    int    checks = 0;
    int    fails  = 0;

    adcc_correct u_adcc_correct (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_codes_i(codes),
        .word_o       (word),
        .word_vld_o   (vld),
        .over_range_o (ovr),
        .code_err_o   (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(int v);
        case (v)
            -1:      return 2'b00;
            0:       return 2'b01;
            1:       return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic void finish_expect(int i, longint d, bit bad);
        longint raw = d + MID;
        exp_ovr[i]  = (raw < 0) || (raw > MAXW);
        exp_word[i] = (raw < 0) ? 0 : (raw > MAXW) ? MAXW : int'(raw);
        exp_err[i]  = bad;
    endfunction

    // behavioural 1.5-bit stage chain with displaced comparator thresholds
    function automatic void build_analog(int i, longint a, int bad_stage);
        longint vref = longint'(1) << F;
        longint q    = longint'(1) << (F - 2);
        longint r = a;
        longint d = 0;
        longint idl;
        for (int k = 0; k < NST; k++) begin
            int v;
            if (r > q + off_hi[k])       v = 1;
            else if (r < -q + off_lo[k]) v = -1;
            else                         v = 0;
            code_mem[i][k] = v;
            r = 2 * r - v * vref;
            d += longint'(v) << (NST - 1 - k);
        end
        if (bad_stage >= 0) begin
            d -= longint'(code_mem[i][bad_stage]) << (NST - 1 - bad_stage);
            code_mem[i][bad_stage] = 2;
        end
        finish_expect(i, d, bad_stage >= 0);
        idl = (a >>> (F - 14)) + MID;
        ideal[i] = (idl < 0) ? 0 : (idl > MAXW) ? MAXW : int'(idl);
    endfunction

    function automatic void build_direct(int i, int s0, int s1, int s13);
        longint d;
        for (int k = 0; k < NST; k++) code_mem[i][k] = 0;
        code_mem[i][0] = s0; code_mem[i][1] = s1; code_mem[i][NST-1] = s13;
        d = (longint'(s0) << 13) + (longint'(s1) << 12) + longint'(s13);
        finish_expect(i, d, 1'b0);
        ideal[i] = -1;
    endfunction

    task automatic check_quiet(string tag);
        chk(vld == 1'b0, "R6", {tag, " valid"}, vld, 0);
        chk(word == '0,  "R7", {tag, " word"}, word, 0);
        chk(ovr == 1'b0 && err == 1'b0, "R7", {tag, " flags"}, {ovr, err}, 0);
    endtask

    task automatic run_stream(int n);
        for (int t = 0; t < n + NST - 1; t++) begin
            for (int k = 0; k < NST; k++) begin
                int s = t - k;
                codes[2*k +: 2] = (s >= 0 && s < n) ? enc(code_mem[s][k]) : 2'b01;
            end
            @(posedge clk);
            @(negedge clk);
            chk(vld == (t >= NST - 1), "R6", "valid flag", vld, t >= NST - 1);
            if (t >= NST - 1) begin
                int s = t - (NST - 1);
                chk(word == exp_word[s], "R2", $sformatf("word of sample %0d", s), word, exp_word[s]);
                chk(ovr == exp_ovr[s], "R4", $sformatf("over-range of sample %0d", s), ovr, exp_ovr[s]);
                chk(err == exp_err[s], "R5", $sformatf("error flag of sample %0d", s), err, exp_err[s]);
                if (!exp_err[s] && ideal[s] >= 0) begin
                    int dv = int'(word) - ideal[s];
                    chk(dv >= -1 && dv <= 1, "R8", $sformatf("ideal distance of sample %0d", s), word, ideal[s]);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(7));
        for (int k = 0; k < NST; k++) begin
            off_hi[k] = longint'($urandom % (1 << (F - 2))) - (longint'(1) << (F - 3));
            off_lo[k] = longint'($urandom % (1 << (F - 2))) - (longint'(1) << (F - 3));
        end
        // R1 single weights, R3 clamp of a hand-built code set
        build_direct(0, 0, 1, 0);     // 12288
        build_direct(1, 0, 0, -1);    // 8191
        build_direct(2, -1, 0, 1);    // 1
        build_direct(3, 1, 0, 0);     // 16384 -> clamped 16383
        build_direct(4, -1, -1, -1);  // below zero -> 0
        build_direct(5, 0, 0, 0);     // mid-scale
        // R8 full-scale corners, R3 over-range both sides
        build_analog(6, 0, -1);
        build_analog(7, (longint'(1) << (F - 1)) - 1, -1);
        build_analog(8, -(longint'(1) << (F - 1)), -1);
        build_analog(9, (longint'(1) << F) - 1, -1);
        build_analog(10, -(longint'(1) << F), -1);
        // R5 illegal code at first, middle and last stage
        build_analog(11, longint'(123457), 0);
        build_analog(12, -longint'(2345671), 7);
        build_analog(13, longint'(3456789), NST - 1);
        for (int i = 14; i < NS; i++) begin
            longint a;
            if (i % 10 == 3) a = longint'($urandom % (1 << (F + 1))) - (longint'(1) << F);
            else             a = longint'($urandom % (1 << F)) - (longint'(1) << (F - 1));
            build_analog(i, a, -1);
        end

        repeat (3) begin
            @(negedge clk);
            check_quiet("in reset");
        end
        rst_n = 1'b1;
        run_stream(NS);

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_quiet("mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        run_stream(40);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule